// File: doc/BRIEF.md
# Programmable Prescaled Down-Count Timer

This block is a single down-counting timer on a plain register bus. Software writes a start value, picks how the counter behaves when it passes zero, and reads the live count back at any time. Three behaviours are available when zero is passed: reload from the stored start value, wrap to the all-ones value of the selected width, or stop and wait for a new start value. A prescaler in front of the counter divides the clock by 1, 16 or 256. The counter can run at 16 or 32 bits.

Each time the count steps down to zero, a sticky event flag is set. The interrupt line is that flag gated by an enable bit. The flag stays set until software writes to a dedicated clear address. The bus has separate read and write strobes, a byte address and 32-bit data. Reads are combinational. Writes take effect at the next rising clock edge.

Top module: `tick_down_timer`

## Requirements
- R1: Byte offset 0 holds the start value (read/write, full 32 bits), offset 4 returns the live count (writes there are ignored), offset 8 is the mode byte, and a write of any data to offset 12 clears the event flag. Other offsets read zero. When rd_en is low, rdata is zero. After reset every register, the count and the interrupt are zero.
- R2: Mode byte fields: bit 7 run enable, bit 6 reload-on-zero (1) or wrap (0), bit 5 interrupt enable, bits 3:2 prescale select, bit 1 32-bit width (1) or 16-bit width (0), bit 0 stop-at-zero. Bit 4 and bits 31:8 read zero and are not stored.
- R3: A write to offset 0 puts the value, masked to the selected width, into the counter at that clock edge and restarts the prescaler.
- R4: Prescale select 00 gives a count step on every enabled cycle, 01 on every 16th and 10 or 11 on every 256th. After a start-value write, the first step falls on the Nth enabled edge after the write edge.
- R5: On each prescaled step a nonzero count decreases by one. In 16-bit mode the count reads with bits 31:16 at zero.
- R6: In wrap mode, a step at zero loads 0xFFFF in 16-bit mode or 0xFFFFFFFF in 32-bit mode.
- R7: In reload mode, a step at zero loads the start value masked to the width.
- R8: With stop-at-zero set, the count holds at zero on further steps until a start value is written. This setting takes precedence over bit 6.
- R9: With the run enable clear, both the count and the prescaler phase hold. Counting resumes from the same phase.
- R10: A step from one to zero sets the event flag. irq equals flag AND interrupt enable. A write to offset 12 clears the flag, and a step to zero in the same cycle wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 4 | Byte address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, combinational |
| irq | output | 1 | Level interrupt |

## Verification
The assertions assume single-cycle strobes with a stable address and data during the strobe cycle, and no X on the strobes once reset is released. The stimulus drives every bus signal on the falling clock edge and holds it for exactly one rising edge. It also changes the prescale select only before a start-value write, so the phase assertions see a defined prescaler state. Reads are combinational and are sampled shortly after the falling edge, so they never overlap a register update.

// File: rtl/dtmr_pkg.sv
package dtmr_pkg;

  localparam int DATA_W = 32;
  localparam int ADDR_W = 4;

  localparam logic [ADDR_W-1:0] OFS_START = 4'h0;
  localparam logic [ADDR_W-1:0] OFS_COUNT = 4'h4;
  localparam logic [ADDR_W-1:0] OFS_MODE  = 4'h8;
  localparam logic [ADDR_W-1:0] OFS_CLEAR = 4'hC;

  typedef struct packed {
    logic       run;
    logic       reload;
    logic       irq_en;
    logic [1:0] psel;
    logic       wide;
    logic       stop0;
  } mode_t;

  function automatic mode_t mode_from_word(input logic [DATA_W-1:0] w);
    mode_t m;
    m.run    = w[7];
    m.reload = w[6];
    m.irq_en = w[5];
    m.psel   = w[3:2];
    m.wide   = w[1];
    m.stop0  = w[0];
    return m;
  endfunction

  function automatic logic [DATA_W-1:0] mode_to_word(input mode_t m);
    logic [DATA_W-1:0] w;
    w = '0;
    w[7]   = m.run;
    w[6]   = m.reload;
    w[5]   = m.irq_en;
    w[3:2] = m.psel;
    w[1]   = m.wide;
    w[0]   = m.stop0;
    return w;
  endfunction

  function automatic logic [DATA_W-1:0] width_mask(input logic wide);
    return wide ? {DATA_W{1'b1}} : {{(DATA_W/2){1'b0}}, {(DATA_W/2){1'b1}}};
  endfunction

endpackage

// File: rtl/dtmr_prescale.sv
module dtmr_prescale #(
  parameter int DIV_MID = 16,
  parameter int DIV_HI  = 256,
  localparam int PRE_W  = $clog2(DIV_HI)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic       restart,
  input  logic [1:0] psel,
  output logic       tick
);

  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] limit;

  function automatic logic [PRE_W-1:0] phase_limit(input logic [1:0] s);
    case (s)
      2'b00:   return '0;
      2'b01:   return PRE_W'(DIV_MID - 1);
      default: return PRE_W'(DIV_HI - 1);
    endcase
  endfunction

  assign limit = phase_limit(psel);
  assign tick  = en && !restart && (pre_q >= limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pre_q <= '0;
    else if (restart) pre_q <= '0;
    else if (tick)    pre_q <= '0;
    else if (en)      pre_q <= pre_q + PRE_W'(1);
  end

  // R9: prescaler phase holds while stopped
  a_r9_phase_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !restart) |=> $stable(pre_q));

  // R4: phase advances by one between steps
  a_r4_phase_step: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !restart && !tick) |=> (pre_q == $past(pre_q) + PRE_W'(1)));

  // R3: restart clears the phase
  a_r3_phase_restart: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (pre_q == '0));

endmodule

// File: rtl/dtmr_core.sv
module dtmr_core
  import dtmr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              tick,
  input  logic              load_wr,
  input  logic [DATA_W-1:0] load_val,
  input  logic              reload,
  input  logic              stop0,
  input  logic              wide,
  output logic [DATA_W-1:0] cnt_q,
  output logic              hit
);

  logic [DATA_W-1:0] mask;
  logic [DATA_W-1:0] cur;
  logic [DATA_W-1:0] cnt_d;
  logic              at_zero;

  assign mask    = width_mask(wide);
  assign cur     = cnt_q & mask;
  assign at_zero = (cur == '0);
  assign hit     = tick && !load_wr && (cur == DATA_W'(1));

  always_comb begin
    cnt_d = cnt_q;
    if (load_wr)         cnt_d = load_val & mask;
    else if (tick) begin
      if (!at_zero)      cnt_d = cur - DATA_W'(1);
      else if (stop0)    cnt_d = '0;
      else if (reload)   cnt_d = load_val & mask;
      else               cnt_d = mask;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R9: count holds while stopped
  a_r9_count_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !load_wr) |=> $stable(cnt_q));

  // R8: stop-at-zero holds zero
  a_r8_stop_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (stop0 && cnt_q == '0 && !load_wr) |=> (cnt_q == '0));

  // R3: start value appears after the write edge
  a_r3_load_copy: assert property (@(posedge clk) disable iff (!rst_n)
    load_wr |=> (cnt_q == ($past(load_val) & $past(mask))));

  // R7: reload at zero
  a_r7_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && at_zero && reload && !stop0 && !load_wr)
      |=> (cnt_q == ($past(load_val) & $past(mask))));

  // R6: wrap to all ones
  a_r6_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && at_zero && !reload && !stop0 && !load_wr) |=> (cnt_q == $past(mask)));

endmodule

// File: rtl/tick_down_timer.sv
module tick_down_timer
  import dtmr_pkg::*;
#(
  parameter int DIV_MID = 16,
  parameter int DIV_HI  = 256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              irq
);

  mode_t             mode_q;
  logic [DATA_W-1:0] start_q;
  logic [DATA_W-1:0] cnt_q;
  logic              flag_q;
  logic              start_wr, mode_wr, clr_wr;
  logic              tick, hit;

  assign start_wr = wr_en && (addr == OFS_START);
  assign mode_wr  = wr_en && (addr == OFS_MODE);
  assign clr_wr   = wr_en && (addr == OFS_CLEAR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= '0;
      mode_q  <= '0;
      flag_q  <= 1'b0;
    end else begin
      if (start_wr) start_q <= wdata;
      if (mode_wr)  mode_q  <= mode_from_word(wdata);
      if (hit)         flag_q <= 1'b1;
      else if (clr_wr) flag_q <= 1'b0;
    end
  end

  dtmr_prescale #(.DIV_MID(DIV_MID), .DIV_HI(DIV_HI)) u_pre (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (mode_q.run),
    .restart (start_wr),
    .psel    (mode_q.psel),
    .tick    (tick)
  );

  dtmr_core u_core (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (mode_q.run),
    .tick     (tick),
    .load_wr  (start_wr),
    .load_val (start_q_next()),
    .reload   (mode_q.reload),
    .stop0    (mode_q.stop0),
    .wide     (mode_q.wide),
    .cnt_q    (cnt_q),
    .hit      (hit)
  );

  // start value seen by the counter: the incoming word on a write edge
  function automatic logic [DATA_W-1:0] start_q_next();
    return start_wr ? wdata : start_q;
  endfunction

  always_comb begin
    rdata = '0;
    if (rd_en) begin
      case (addr)
        OFS_START: rdata = start_q;
        OFS_COUNT: rdata = cnt_q & width_mask(mode_q.wide);
        OFS_MODE:  rdata = mode_to_word(mode_q);
        default:   rdata = '0;
      endcase
    end
  end

  assign irq = flag_q && mode_q.irq_en;

  // R10: a step to zero always leaves the flag set
  a_r10_hit_sets: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> flag_q);

  // R10: clear without a coincident step drops the flag
  a_r10_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_wr && !hit) |=> !flag_q);

  // R2: stored mode never carries a reserved bit into the read path
  a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    mode_wr |=> (mode_to_word(mode_q) == ($past(wdata) & 32'h0000_00EF)));

endmodule

// File: tb/tick_down_timer_bench.sv
module tick_down_timer_bench;

  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  int n_chk = 0;
  int n_bad = 0;

  always #(PERIOD/2) clk = ~clk;

  tick_down_timer u_tick_down_timer (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [31:0] exp, input string tag);
    addr = a; rd_en = 1'b1;
    #1;
    chk(tag, rdata, exp);
    rd_en = 1'b0;
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    rd(4'h0, 32'h0, "R1 start after reset");
    rd(4'h4, 32'h0, "R1 count after reset");
    rd(4'h8, 32'h0, "R1 mode after reset");
    chk("R1 irq after reset", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_map;
    wr(4'h8, 32'hFFFF_FFFF);
    rd(4'h8, 32'h0000_00EF, "R2 reserved bits read zero");
    wr(4'h8, 32'h0000_0002);
    wr(4'h0, 32'h77);
    wr(4'h4, 32'h55);
    rd(4'h4, 32'h77, "R1 count write ignored");
    rd(4'hC, 32'h0, "R1 clear offset reads zero");
    addr = 4'h0; #1;
    chk("R1 rdata zero without rd_en", rdata, 32'h0);
  endtask

  task automatic t_reload;
    wr(4'h8, 32'hC2);
    wr(4'h0, 32'd10);
    rd(4'h4, 32'd10, "R3 start copied");
    cyc(4);  rd(4'h4, 32'd6, "R5 decrement");
    cyc(6);  rd(4'h4, 32'd0, "R5 reaches zero");
    cyc(1);  rd(4'h4, 32'd10, "R7 reload at zero");
    cyc(1);  rd(4'h4, 32'd9, "R7 counting after reload");
  endtask

  task automatic t_irq;
    wr(4'hC, 32'h0);
    wr(4'h8, 32'hE2);
    wr(4'h0, 32'd3);
    cyc(2); chk("R10 irq low before zero", {31'b0, irq}, 32'h0);
    cyc(1); chk("R10 irq at zero", {31'b0, irq}, 32'h1);
    wr(4'hC, 32'h0);
    chk("R10 clear drops irq", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_mask_freeze;
    wr(4'hC, 32'h0);
    wr(4'h8, 32'hC2);
    wr(4'h0, 32'd2);
    cyc(2);
    chk("R10 irq masked by enable bit", {31'b0, irq}, 32'h0);
    wr(4'h8, 32'h22);
    chk("R10 flag sticky, irq on enable", {31'b0, irq}, 32'h1);
    rd(4'h4, 32'd2, "R7 reload on final enabled edge");
    cyc(5);
    rd(4'h4, 32'd2, "R9 count frozen when stopped");
    wr(4'hC, 32'h0);
    chk("R10 clear while stopped", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_wrap;
    wr(4'h8, 32'h80);
    wr(4'h0, 32'h0001_0002);
    rd(4'h0, 32'h0001_0002, "R1 start keeps 32 bits");
    rd(4'h4, 32'd2, "R3 start masked to 16 bits");
    cyc(2); rd(4'h4, 32'd0, "R5 16-bit zero");
    cyc(1); rd(4'h4, 32'h0000_FFFF, "R6 16-bit wrap");
    cyc(1); rd(4'h4, 32'h0000_FFFE, "R6 16-bit after wrap");
    wr(4'h8, 32'h82);
    wr(4'h0, 32'd1);
    cyc(1); rd(4'h4, 32'd0, "R5 32-bit zero");
    cyc(1); rd(4'h4, 32'hFFFF_FFFF, "R6 32-bit wrap");
  endtask

  task automatic t_stop;
    wr(4'h8, 32'hC3);
    wr(4'h0, 32'd2);
    cyc(2); rd(4'h4, 32'd0, "R8 reaches zero");
    cyc(5); rd(4'h4, 32'd0, "R8 holds zero over reload mode");
    wr(4'h0, 32'd5);
    rd(4'h4, 32'd5, "R8 restart by start write");
  endtask

  task automatic t_prescale;
    wr(4'h8, 32'h86);
    wr(4'h0, 32'd100);
    cyc(15); rd(4'h4, 32'd100, "R4 div16 before step");
    cyc(1);  rd(4'h4, 32'd99,  "R4 div16 first step");
    cyc(16); rd(4'h4, 32'd98,  "R4 div16 second step");
    wr(4'h8, 32'h8A);
    wr(4'h0, 32'd50);
    cyc(255); rd(4'h4, 32'd50, "R4 div256 before step");
    cyc(1);   rd(4'h4, 32'd49, "R4 div256 first step");
  endtask

  task automatic t_restart;
    wr(4'h8, 32'h86);
    wr(4'h0, 32'd100);
    cyc(10);
    wr(4'h0, 32'd200);
    cyc(15); rd(4'h4, 32'd200, "R3 prescaler restarted");
    cyc(1);  rd(4'h4, 32'd199, "R3 step after restart");
  endtask

  task automatic t_phase_hold;
    wr(4'h8, 32'h86);
    wr(4'h0, 32'd100);
    cyc(10);
    wr(4'h8, 32'h06);
    cyc(20);
    wr(4'h8, 32'h86);
    cyc(4); rd(4'h4, 32'd100, "R9 phase kept, no step yet");
    cyc(1); rd(4'h4, 32'd99,  "R9 phase kept, step due");
  endtask

  initial begin
    #(PERIOD * 150000);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
    t_reset();
    t_map();
    t_reload();
    t_irq();
    t_mask_freeze();
    t_wrap();
    t_stop();
    t_prescale();
    t_restart();
    t_phase_hold();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule